// File: doc/BRIEF.md
# Buffered-Duty PWM Generator

This block drives one pulse-width-modulated output from a 10-bit up-counter. The counter advances only on ticks from a prescaler, which divides the clock by 1, 2, 4 and so on up to 128. Software programs the block through a write port with four registers. One is a control word holding the enable, the divider select and a flag-clear strobe. The others are an 8-bit period, a 10-bit pending duty and the counter itself. The live counter value is always visible on a read port.

When the counter equals the period, the next tick starts a new cycle. That tick resets the counter to zero, copies the pending duty into a working latch, raises the output and sets a sticky interrupt flag. The output falls on the tick that brings the counter to the latched duty. A duty of zero holds the output low for the whole cycle. A duty beyond the period holds it high for the whole cycle. A duty written in mid-cycle has no effect until the next boundary, so the waveform never shows a glitched cycle.

Top module: `pwm_buffered_duty`

## Requirements
- R1: After reset, the counter reads 0, the output and interrupt flag are 0, the block is disabled, the pending duty is 0 and the period is 255.
- R2: Writes use address 3 to load the counter at once, in any state; a write of 0 clears it. The write takes priority over a tick in that cycle. While enabled, each prescaler tick adds 1 to the counter, and the counter value is always visible on cnt_o.
- R3: On the first tick after the counter equals the period, the counter becomes 0. The 8-bit period at address 1, data bits 7:0, is zero-extended before the compare. A period P therefore gives a cycle of P+1 ticks.
- R4: On that boundary tick the pending duty is copied to the working latch and the output goes high. The output goes low on the tick that brings the counter to the latched duty D, so it stays high for D ticks.
- R5: A duty written at address 2, data bits 9:0, during a cycle does not change that cycle's waveform. It takes effect at the next boundary.
- R6: If the duty latched at a boundary is 0, the output stays low for the whole cycle.
- R7: If the latched duty exceeds the period, the output stays high for the whole cycle, and the boundary still sets the interrupt flag.
- R8: Every boundary sets the interrupt flag. The flag stays set until a control write, at address 0, carries a 1 in bit 4. A boundary in the same cycle as that write wins.
- R9: Control bits 3:1 select a prescaler divide of 2^sel, from 1:1 to 1:128, so every waveform interval scales by 2^sel clock cycles.
- R10: While control bit 0 (enable) is 0, the counter holds its value, the prescaler is idle and the output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 control, 1 period, 2 duty, 3 counter |
| wr_data_i | input | 10 | Write data |
| cnt_o | output | 10 | Live counter value |
| pwm_o | output | 1 | PWM output |
| irq_o | output | 1 | Sticky period interrupt flag |

## Verification
Some rules are checked on every cycle by the assertions:
- the counter steps by one per tick, returns to zero after a period match and holds when idle;
- the prescaler never gives back-to-back ticks at a divided rate;
- the output rises only on a boundary, never rises on a zero duty and drops when disabled;
- the flag is set by each boundary and stays set until cleared.

Other behaviour only the directed scenarios can show, by counting high and low intervals at the pin. These are the exact high and low widths for a given period, duty and divider, and the delay of a mid-cycle duty change to the next cycle. They also cover the all-high waveform when the duty is beyond the period, and the 255 period that proves the zero-extension.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_PERIOD = 2'd1,
    ADDR_DUTY   = 2'd2,
    ADDR_COUNT  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int PER_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             en_o,
  output logic [SEL_W-1:0] sel_o,
  output logic [PER_W-1:0] period_o,
  output logic [CNT_W-1:0] duty_o,
  output logic             cnt_wr_o,
  output logic [CNT_W-1:0] cnt_data_o,
  output logic             irq_clr_o
);
  localparam int CLR_BIT = SEL_W + 1;

  logic ctrl_wr, per_wr, duty_wr;

  assign ctrl_wr  = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign per_wr   = wr_en_i && (wr_addr_i == ADDR_PERIOD);
  assign duty_wr  = wr_en_i && (wr_addr_i == ADDR_DUTY);
  assign cnt_wr_o = wr_en_i && (wr_addr_i == ADDR_COUNT);

  assign cnt_data_o = wr_data_i;
  assign irq_clr_o  = ctrl_wr && wr_data_i[CLR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o     <= 1'b0;
      sel_o    <= '0;
      period_o <= '1;
      duty_o   <= '0;
    end else begin
      if (ctrl_wr) begin
        en_o  <= wr_data_i[0];
        sel_o <= wr_data_i[SEL_W:1];
      end
      if (per_wr)  period_o <= wr_data_i[PER_W-1:0];
      if (duty_wr) duty_o   <= wr_data_i;
    end
  end

  // Unused upper write-data bits on ctrl/period writes are intentionally dropped
  logic unused_hi;
  assign unused_hi = ^wr_data_i[CNT_W-1:CLR_BIT+1];

  AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({ctrl_wr, per_wr, duty_wr, cnt_wr_o}) <= 1); // R2
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             sync_clr_i,
  output logic             tick_o
);
  localparam int PS_W = (1 << SEL_W) - 1;

  logic [PS_W-1:0] ps_q;
  logic [PS_W-1:0] mask;

  for (genvar b = 0; b < PS_W; b++) begin : g_mask
    assign mask[b] = (sel_i > SEL_W'(b));
  end

  assign tick_o = en_i && ((ps_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ps_q <= '0;
    else if (!en_i || sync_clr_i) ps_q <= '0;
    else                         ps_q <= ps_q + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && (sel_i != '0) && !sync_clr_i |=> !tick_o || (sel_i != $past(sel_i))); // R9
  AST_IDLE_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (ps_q == '0)); // R10
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 10,
  parameter int PER_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] cnt_data_i,
  input  logic [PER_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             cnt_upd_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] per_ext;

  assign per_ext   = {{(CNT_W-PER_W){1'b0}}, period_i};
  assign hit_o     = tick_i && !cnt_wr_i && (cnt_q == per_ext);
  assign cnt_upd_o = tick_i || cnt_wr_i;

  always_comb begin
    cnt_nxt_o = cnt_q;
    if (cnt_wr_i)    cnt_nxt_o = cnt_data_i;
    else if (hit_o)  cnt_nxt_o = '0;
    else if (tick_i) cnt_nxt_o = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt_o;
  end

  assign cnt_o = cnt_q;

  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !cnt_wr_i && (cnt_q == per_ext) |=> (cnt_q == '0)); // R3
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !cnt_wr_i && (cnt_q != per_ext) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2
  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_i |=> (cnt_q == $past(cnt_data_i))); // R2
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !cnt_wr_i |=> $stable(cnt_q)); // R10
endmodule

// File: rtl/pwm_wave.sv
module pwm_wave #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             hit_i,
  input  logic             cnt_upd_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             irq_clr_i,
  output logic             pwm_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] duty_lat;
  logic             pwm_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_lat <= '0;
      pwm_q    <= 1'b0;
    end else if (!en_i) begin
      pwm_q <= 1'b0;
    end else if (hit_i) begin
      duty_lat <= duty_i;
      pwm_q    <= (duty_i != '0);
    end else if (cnt_upd_i && (cnt_nxt_i == duty_lat)) begin
      // compare the incoming count so the edge lands on the matching tick
      pwm_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_q <= 1'b0;
    else if (hit_i)     irq_q <= 1'b1;
    else if (irq_clr_i) irq_q <= 1'b0;
  end

  assign pwm_o = pwm_q;
  assign irq_o = irq_q;

  AST_ZERO_DUTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i && en_i && (duty_i == '0) |=> !pwm_q); // R6
  AST_RISE_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwm_q && !hit_i |=> !pwm_q); // R4
  AST_IRQ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> irq_q); // R8
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q && !irq_clr_i |=> irq_q); // R8
  AST_OFF_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pwm_q); // R10
endmodule

// File: rtl/pwm_buffered_duty.sv
module pwm_buffered_duty #(
  parameter int CNT_W = 10,
  parameter int PER_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pwm_o,
  output logic             irq_o
);
  logic             en, cnt_wr, irq_clr, tick, hit, cnt_upd;
  logic [SEL_W-1:0] sel;
  logic [PER_W-1:0] period;
  logic [CNT_W-1:0] duty, cnt_data, cnt_nxt;

  pwm_regs #(.CNT_W(CNT_W), .PER_W(PER_W), .SEL_W(SEL_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .en_o(en), .sel_o(sel), .period_o(period), .duty_o(duty),
    .cnt_wr_o(cnt_wr), .cnt_data_o(cnt_data), .irq_clr_o(irq_clr)
  );

  pwm_prescaler #(.SEL_W(SEL_W)) u_presc (
    .clk_i, .rst_ni, .en_i(en), .sel_i(sel), .sync_clr_i(cnt_wr), .tick_o(tick)
  );

  pwm_timebase #(.CNT_W(CNT_W), .PER_W(PER_W)) u_tb (
    .clk_i, .rst_ni, .tick_i(tick), .cnt_wr_i(cnt_wr), .cnt_data_i(cnt_data),
    .period_i(period), .cnt_o(cnt_o), .cnt_nxt_o(cnt_nxt), .cnt_upd_o(cnt_upd),
    .hit_o(hit)
  );

  pwm_wave #(.CNT_W(CNT_W)) u_wave (
    .clk_i, .rst_ni, .en_i(en), .hit_i(hit), .cnt_upd_i(cnt_upd),
    .cnt_nxt_i(cnt_nxt), .duty_i(duty), .irq_clr_i(irq_clr),
    .pwm_o(pwm_o), .irq_o(irq_o)
  );
endmodule

// File: tb/tb_pwm_buffered_duty.sv
`timescale 1ns/1ps
module tb_pwm_buffered_duty;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [9:0] wr_data_i = '0;
  logic [9:0] cnt_o;
  logic       pwm_o, irq_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i; // 50 MHz

  pwm_buffered_duty dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [9:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  function automatic logic [9:0] ctrl(input bit en, input int sel, input bit clr);
    return {5'b0, clr, sel[2:0], en};
  endfunction

  // counts negedges high and low from a rising edge of pwm_o
  task automatic measure(output int hi, output int lo, input bit synced,
                         input bit mid_wr, input logic [9:0] mid_duty);
    int guard = 0;
    if (!synced) begin
      while (pwm_o !== 1'b0 && guard < 5000) begin @(negedge clk_i); guard++; end
      while (pwm_o !== 1'b1 && guard < 5000) begin @(negedge clk_i); guard++; end
    end
    hi = 0; lo = 0;
    if (mid_wr) begin wr_en_i = 1'b1; wr_addr_i = 2'd2; wr_data_i = mid_duty; end
    while (pwm_o === 1'b1 && hi < 5000) begin hi++; @(negedge clk_i); wr_en_i = 1'b0; end
    while (pwm_o === 1'b0 && lo < 5000) begin lo++; @(negedge clk_i); end
  endtask

  task automatic wait_irq(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk_i);
      if (irq_o === 1'b1) begin seen = 1'b1; break; end
    end
  endtask

  task automatic t_reset;
    chk(cnt_o == 0, "R1 counter", int'(cnt_o), 0);
    chk(pwm_o == 0, "R1 pwm", int'(pwm_o), 0);
    chk(irq_o == 0, "R1 irq", int'(irq_o), 0);
  endtask

  task automatic t_counter_rw;
    int c0;
    wr(2'd3, 10'd5);
    chk(cnt_o == 5, "R2 load while idle", int'(cnt_o), 5);
    wr(2'd0, ctrl(1, 0, 0));
    repeat (3) @(negedge clk_i);
    chk(cnt_o == 8, "R2 count on ticks", int'(cnt_o), 8);
    wr(2'd0, ctrl(0, 0, 0));
    c0 = int'(cnt_o);
    repeat (5) @(negedge clk_i);
    chk(int'(cnt_o) == c0, "R10 counter holds", int'(cnt_o), c0);
    chk(pwm_o == 0, "R10 pwm low idle", int'(pwm_o), 0);
    wr(2'd3, 10'd0);
    chk(cnt_o == 0, "R2 clear", int'(cnt_o), 0);
  endtask

  task automatic t_basic;
    int hi, lo;
    wr(2'd1, 10'd9);
    wr(2'd2, 10'd4);
    wr(2'd0, ctrl(1, 0, 0));
    measure(hi, lo, 0, 0, '0);
    chk(hi == 4, "R4 high ticks", hi, 4);
    chk(hi + lo == 10, "R3 cycle length", hi + lo, 10);
  endtask

  task automatic t_double_buffer;
    int hi, lo;
    measure(hi, lo, 0, 1, 10'd7);
    chk(hi == 4, "R5 current cycle unchanged", hi, 4);
    chk(lo == 6, "R5 current low", lo, 6);
    measure(hi, lo, 1, 0, '0);
    chk(hi == 7, "R5 new duty next cycle", hi, 7);
    chk(lo == 3, "R5 new low", lo, 3);
  endtask

  task automatic t_prescale;
    int hi, lo;
    wr(2'd0, ctrl(0, 0, 0));
    wr(2'd3, 10'd0);
    wr(2'd1, 10'd3);
    wr(2'd2, 10'd2);
    wr(2'd0, ctrl(1, 2, 0));
    measure(hi, lo, 0, 0, '0);
    chk(hi == 8, "R9 high at 1:4", hi, 8);
    chk(lo == 8, "R9 low at 1:4", lo, 8);
  endtask

  task automatic t_full_period;
    int hi, lo;
    wr(2'd0, ctrl(0, 0, 0));
    wr(2'd3, 10'd0);
    wr(2'd1, 10'd255);
    wr(2'd2, 10'd128);
    wr(2'd0, ctrl(1, 0, 0));
    measure(hi, lo, 0, 0, '0);
    chk(hi == 128, "R3 period 255 high", hi, 128);
    chk(hi + lo == 256, "R3 zero-extended period", hi + lo, 256);
  endtask

  task automatic t_irq;
    bit seen;
    wr(2'd0, ctrl(0, 0, 1));
    wr(2'd3, 10'd0);
    wr(2'd1, 10'd9);
    wr(2'd2, 10'd4);
    chk(irq_o == 0, "R8 cleared", int'(irq_o), 0);
    wr(2'd0, ctrl(1, 0, 0));
    wait_irq(seen);
    chk(seen, "R8 flag set at boundary", int'(seen), 1);
    chk(cnt_o == 0, "R3 counter zero at boundary", int'(cnt_o), 0);
    chk(pwm_o == 1, "R4 rise at boundary", int'(pwm_o), 1);
    wr(2'd0, ctrl(1, 0, 1));
    chk(irq_o == 0, "R8 clear by write", int'(irq_o), 0);
    repeat (4) @(negedge clk_i);
    chk(irq_o == 0, "R8 stays clear mid-cycle", int'(irq_o), 0);
    wait_irq(seen);
    repeat (25) @(negedge clk_i);
    chk(irq_o == 1, "R8 sticky", int'(irq_o), 1);
  endtask

  task automatic t_zero_duty;
    bit seen;
    int highs = 0;
    wr(2'd2, 10'd0);
    wr(2'd0, ctrl(1, 0, 1));
    wait_irq(seen);
    wr(2'd0, ctrl(1, 0, 1));
    for (int i = 0; i < 30; i++) begin
      @(negedge clk_i);
      if (pwm_o !== 1'b0) highs++;
    end
    chk(highs == 0, "R6 zero duty keeps low", highs, 0);
    chk(irq_o == 1, "R8 flag with zero duty", int'(irq_o), 1);
  endtask

  task automatic t_big_duty;
    bit seen;
    int lows = 0;
    wr(2'd2, 10'd20);
    wr(2'd0, ctrl(1, 0, 1));
    wait_irq(seen);
    chk(seen, "R7 flag with wide duty", int'(seen), 1);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk_i);
      if (pwm_o !== 1'b1) lows++;
    end
    chk(lows == 0, "R7 wide duty stays high", lows, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_counter_rw();
    t_basic();
    t_double_buffer();
    t_prescale();
    t_full_period();
    t_irq();
    t_zero_duty();
    t_big_duty();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule